// File: doc/BRIEF.md
# Lock-Step Processing-Element Grid with Neighbor Links

This block is a data-parallel array of processing elements laid out as a square grid (8 by 8 by default). A central sequencer takes one broadcast command per clock and hands it to every element at once. Each element holds one data register, one mask bit and a small private memory. A command either runs a local operation on the data register, or moves every data register one hop along the grid. Elements whose mask bit is clear skip the operation for that cycle.

Each element has direct links only to the elements whose linear index differs by one or by one row width. Data bound for a distant element must be relayed, one hop per move command. A host outside the array can reach any word of any element's memory through a simple memory-style port. The host may use the port only while the array is idle. A busy flag rises with the first command of a sequence and falls with the terminating command.

Top module: `simd_grid_array`

## Requirements
- R1: After reset, busy is 0, every data register and every memory word reads 0, and every mask bit is 1.
- R2: Command codes on cmd_op are: 0 no-op, 1 load immediate, 2 load own element index, 3 add immediate, 4 xor immediate, 5 add memory word, 6 load memory word, 7 store data to memory word, 8 move, 9 compare-less-than, 10 set all masks, 11 end. Arithmetic wraps modulo 2^DW. An unmasked element updates its data register on the clock edge of the command.
- R3: On a move (code 8), each unmasked element j latches the old data register of one neighbor, chosen by cmd_dir: 00 takes from j-1, 01 from j+1, 10 from j-W, 11 from j+W (W is the row width). Indices wrap modulo the element count, and all elements latch on the same edge.
- R4: Data reaches a non-adjacent element only through repeated moves. Two moves with code 10 shift every value by 2W positions.
- R5: Compare (code 9) sets each element's mask to (data < cmd_imm, unsigned) in every element, whatever its old mask. Set-masks (code 10) sets all masks to 1.
- R6: An element whose mask is 0 leaves its data register and its memory unchanged for codes 1 to 8.
- R7: Store (code 7) writes the data register into memory word cmd_addr. Load (code 6) and add-memory (code 5) read memory word cmd_addr.
- R8: Any accepted command other than end makes busy 1 from the next cycle on. End (code 11) makes busy 0 from the next cycle on.
- R9: A host request is accepted when busy is 0 and cmd_valid is 0. host_ack is then 1 in the next cycle, and on a read host_rdata holds the addressed word. A write updates word host_addr of element host_pe.
- R10: A host request made while busy is 1, or in the same cycle as cmd_valid, gets no acknowledge and leaves every memory word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A broadcast command is present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_dir | input | 2 | Move direction code |
| cmd_imm | input | DW | Immediate operand |
| cmd_addr | input | AW | Local memory word for memory commands |
| busy | output | 1 | A broadcast sequence is in progress |
| host_en | input | 1 | Host memory request |
| host_we | input | 1 | Host request is a write |
| host_pe | input | IDXW | Target element index |
| host_addr | input | AW | Word within the element memory |
| host_wdata | input | DW | Host write data |
| host_ack | output | 1 | Request accepted in the previous cycle |
| host_rdata | output | DW | Read data, valid with host_ack |

## Verification
A data register that went wrong, or a mask bit that went wrong, shows up at the ports only once a store copies that register into memory and the host reads the word back. The bench therefore closes every sequence with stores and then sweeps the whole memory, so one bad element in one cycle surfaces within that sweep. A move direction mixed up, or a wrap missing at the array edge, distorts the element-index pattern at the first and last rows. A busy flag that stays stuck shows at the next host request, through a missing or unexpected acknowledge.

// File: rtl/simd_grid_pkg.sv
package simd_grid_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LDI   = 4'd1,
        OP_LDPE  = 4'd2,
        OP_ADDI  = 4'd3,
        OP_XORI  = 4'd4,
        OP_ADDM  = 4'd5,
        OP_LDM   = 4'd6,
        OP_STM   = 4'd7,
        OP_MOVE  = 4'd8,
        OP_CMPLT = 4'd9,
        OP_MSET  = 4'd10,
        OP_END   = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        DIR_FWD_ONE = 2'd0,
        DIR_BWD_ONE = 2'd1,
        DIR_FWD_ROW = 2'd2,
        DIR_BWD_ROW = 2'd3
    } dir_e;

    typedef struct packed {
        logic valid;
        op_e  op;
        dir_e dir;
    } ctl_t;

    function automatic logic op_updates_data(op_e op);
        case (op)
            OP_LDI, OP_LDPE, OP_ADDI, OP_XORI,
            OP_ADDM, OP_LDM, OP_MOVE: return 1'b1;
            default:                  return 1'b0;
        endcase
    endfunction

    function automatic int wrap_index(int i, int n);
        return ((i % n) + n) % n;
    endfunction

endpackage

// File: rtl/simd_seq_ctrl.sv
module simd_seq_ctrl
    import simd_grid_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    input  logic [1:0] cmd_dir,
    input  logic       host_en,
    output ctl_t       ctl,
    output logic       busy,
    output logic       host_acc
);

    logic busy_q;

    always_comb begin
        ctl.valid = cmd_valid;
        ctl.op    = op_e'(cmd_op);
        ctl.dir   = dir_e'(cmd_dir);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
        end else if (cmd_valid) begin
            busy_q <= (op_e'(cmd_op) != OP_END);
        end
    end

    assign busy     = busy_q;
    assign host_acc = host_en & ~busy_q & ~cmd_valid;

    AST_BUSY_RISES: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op != OP_END) |=> busy); // R8
    AST_BUSY_FALLS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_END) |=> !busy); // R8
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(busy)); // R8

endmodule

// File: rtl/simd_pe_cell.sv
module simd_pe_cell
    import simd_grid_pkg::*;
#(
    parameter int DW        = 8,
    parameter int MEM_DEPTH = 4,
    parameter int IDX       = 0,
    localparam int AW       = $clog2(MEM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl,
    input  logic [DW-1:0] imm,
    input  logic [AW-1:0] addr,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] nb_lo1,
    input  logic [DW-1:0] nb_hi1,
    input  logic [DW-1:0] nb_lo_row,
    input  logic [DW-1:0] nb_hi_row,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0] mem [MEM_DEPTH];
    logic          mask_q;
    logic [DW-1:0] mem_word;
    logic [DW-1:0] nb_sel;
    logic [DW-1:0] data_next;

    assign mem_word = mem[addr];
    assign rd_word  = mem[host_addr];

    always_comb begin
        case (ctl.dir)
            DIR_FWD_ONE: nb_sel = nb_lo1;
            DIR_BWD_ONE: nb_sel = nb_hi1;
            DIR_FWD_ROW: nb_sel = nb_lo_row;
            default:     nb_sel = nb_hi_row;
        endcase
    end

    always_comb begin
        case (ctl.op)
            OP_LDI:  data_next = imm;
            OP_LDPE: data_next = DW'(IDX);
            OP_ADDI: data_next = data_q + imm;
            OP_XORI: data_next = data_q ^ imm;
            OP_ADDM: data_next = data_q + mem_word;
            OP_LDM:  data_next = mem_word;
            OP_MOVE: data_next = nb_sel;
            default: data_next = data_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            mask_q <= 1'b1;
            for (int k = 0; k < MEM_DEPTH; k++) mem[k] <= '0;
        end else if (ctl.valid) begin
            if (mask_q && op_updates_data(ctl.op)) data_q <= data_next;
            if (mask_q && ctl.op == OP_STM)        mem[addr] <= data_q;
            if (ctl.op == OP_CMPLT)                mask_q <= (data_q < imm);
            else if (ctl.op == OP_MSET)            mask_q <= 1'b1;
        end else if (host_wr) begin
            mem[host_addr] <= host_wdata;
        end
    end

    AST_MASKED_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl.valid && !mask_q && ctl.op != OP_CMPLT && ctl.op != OP_MSET)
        |=> $stable(data_q)); // R6
    AST_MOVE_FWD_SRC: assert property (@(posedge clk) disable iff (rst)
        (ctl.valid && mask_q && ctl.op == OP_MOVE && ctl.dir == DIR_FWD_ONE)
        |=> data_q == $past(nb_lo1)); // R3
    AST_LDI_TAKES_IMM: assert property (@(posedge clk) disable iff (rst)
        (ctl.valid && mask_q && ctl.op == OP_LDI) |=> data_q == $past(imm)); // R2
    AST_STORE_WRITES: assert property (@(posedge clk) disable iff (rst)
        (ctl.valid && mask_q && ctl.op == OP_STM && addr == host_addr)
        |=> rd_word == $past(data_q)); // R7

endmodule

// File: rtl/simd_grid_array.sv
module simd_grid_array
    import simd_grid_pkg::*;
#(
    parameter int DW        = 8,
    parameter int MEM_DEPTH = 4,
    parameter int GRID_W    = 8,
    parameter int GRID_H    = 8,
    localparam int NPE      = GRID_W * GRID_H,
    localparam int AW       = $clog2(MEM_DEPTH),
    localparam int IDXW     = $clog2(NPE)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [3:0]      cmd_op,
    input  logic [1:0]      cmd_dir,
    input  logic [DW-1:0]   cmd_imm,
    input  logic [AW-1:0]   cmd_addr,
    output logic            busy,
    input  logic            host_en,
    input  logic            host_we,
    input  logic [IDXW-1:0] host_pe,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic            host_ack,
    output logic [DW-1:0]   host_rdata
);

    ctl_t          ctl;
    logic          host_acc;
    logic [DW-1:0] pe_data [NPE];
    logic [DW-1:0] pe_rd   [NPE];

    simd_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_dir   (cmd_dir),
        .host_en   (host_en),
        .ctl       (ctl),
        .busy      (busy),
        .host_acc  (host_acc)
    );

    for (genvar g = 0; g < NPE; g++) begin : g_pe
        localparam int LO1  = wrap_index(g - 1, NPE);
        localparam int HI1  = wrap_index(g + 1, NPE);
        localparam int LOR  = wrap_index(g - GRID_W, NPE);
        localparam int HIR  = wrap_index(g + GRID_W, NPE);
        logic sel_wr;
        assign sel_wr = host_acc & host_we & (host_pe == IDXW'(g));

        simd_pe_cell #(
            .DW        (DW),
            .MEM_DEPTH (MEM_DEPTH),
            .IDX       (g)
        ) u_pe (
            .clk        (clk),
            .rst        (rst),
            .ctl        (ctl),
            .imm        (cmd_imm),
            .addr       (cmd_addr),
            .host_wr    (sel_wr),
            .host_addr  (host_addr),
            .host_wdata (host_wdata),
            .nb_lo1     (pe_data[LO1]),
            .nb_hi1     (pe_data[HI1]),
            .nb_lo_row  (pe_data[LOR]),
            .nb_hi_row  (pe_data[HIR]),
            .data_q     (pe_data[g]),
            .rd_word    (pe_rd[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack <= host_acc;
            if (host_acc && !host_we) host_rdata <= pe_rd[host_pe];
        end
    end

    AST_HOST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        busy |=> !host_ack); // R10
    AST_HOST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !host_ack); // R10
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> $past(host_en)); // R9

endmodule

// File: tb/simd_grid_array_tb.sv
module simd_grid_array_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int MD   = 4;
    localparam int W    = 8;
    localparam int NPE  = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [3:0] cmd_op;
    logic [1:0] cmd_dir;
    logic [7:0] cmd_imm;
    logic [1:0] cmd_addr;
    logic       busy;
    logic       host_en;
    logic       host_we;
    logic [5:0] host_pe;
    logic [1:0] host_addr;
    logic [7:0] host_wdata;
    logic       host_ack;
    logic [7:0] host_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic [7:0] exp_reg  [NPE];
    logic       exp_mask [NPE];
    logic [7:0] exp_mem  [NPE][MD];
    logic       exp_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_grid_array dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dir(cmd_dir), .cmd_imm(cmd_imm), .cmd_addr(cmd_addr),
        .busy(busy), .host_en(host_en), .host_we(host_we), .host_pe(host_pe),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata)
    );

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic int src_of(int j, logic [1:0] d);
        case (d)
            2'd0: return (j + NPE - 1) % NPE;
            2'd1: return (j + 1) % NPE;
            2'd2: return (j + NPE - W) % NPE;
            default: return (j + W) % NPE;
        endcase
    endfunction

    task automatic model(logic [3:0] op, logic [1:0] d, logic [7:0] imm, logic [1:0] a);
        logic [7:0] old [NPE];
        for (int j = 0; j < NPE; j++) old[j] = exp_reg[j];
        for (int j = 0; j < NPE; j++) begin
            if (exp_mask[j]) begin
                case (op)
                    4'd1: exp_reg[j] = imm;
                    4'd2: exp_reg[j] = 8'(j);
                    4'd3: exp_reg[j] = old[j] + imm;
                    4'd4: exp_reg[j] = old[j] ^ imm;
                    4'd5: exp_reg[j] = old[j] + exp_mem[j][a];
                    4'd6: exp_reg[j] = exp_mem[j][a];
                    4'd7: exp_mem[j][a] = old[j];
                    4'd8: exp_reg[j] = old[src_of(j, d)];
                    default: ;
                endcase
            end
            if (op == 4'd9) exp_mask[j] = (old[j] < imm);
            if (op == 4'd10) exp_mask[j] = 1'b1;
        end
        exp_busy = (op != 4'd11);
    endtask

    // entered and left at a falling edge
    task automatic issue(logic [3:0] op, logic [1:0] d, logic [7:0] imm, logic [1:0] a);
        host_en = 0; cmd_valid = 1; cmd_op = op; cmd_dir = d; cmd_imm = imm; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 0;
        model(op, d, imm, a);
    endtask

    task automatic host_read(int pe, int a, string rq);
        cmd_valid = 0; host_en = 1; host_we = 0; host_pe = 6'(pe); host_addr = 2'(a);
        @(negedge clk);
        host_en = 0;
        check({rq, " ack"}, 32'(host_ack), 32'd1);
        check({rq, " data"}, 32'(host_rdata), 32'(exp_mem[pe][a]));
    endtask

    task automatic host_write(int pe, int a, logic [7:0] v);
        cmd_valid = 0; host_en = 1; host_we = 1; host_pe = 6'(pe); host_addr = 2'(a);
        host_wdata = v;
        @(negedge clk);
        host_en = 0;
        check("R9 write ack", 32'(host_ack), 32'd1);
        exp_mem[pe][a] = v;
    endtask

    task automatic sweep(int a, string rq);
        for (int p = 0; p < NPE; p++) host_read(p, a, rq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; cmd_valid = 0; cmd_op = 0; cmd_dir = 0; cmd_imm = 0; cmd_addr = 0;
        host_en = 0; host_we = 0; host_pe = 0; host_addr = 0; host_wdata = 0;
        for (int j = 0; j < NPE; j++) begin
            exp_reg[j] = 0; exp_mask[j] = 1;
            for (int a = 0; a < MD; a++) exp_mem[j][a] = 0;
        end
        exp_busy = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        check("R1 busy after reset", 32'(busy), 32'd0);
        for (int a = 0; a < MD; a++) sweep(a, "R1 memory cleared");
        issue(4'd7, 2'd0, 8'd0, 2'd1);
        check("R8 busy after store", 32'(busy), 32'd1);
        issue(4'd11, 2'd0, 8'd0, 2'd0);
        check("R8 busy after end", 32'(busy), 32'd0);
        sweep(1, "R1 data regs zero");

        // R3 single hop forward with wrap, R2 index load
        issue(4'd2, 2'd0, 8'd0, 2'd0);
        issue(4'd8, 2'd0, 8'd0, 2'd0);
        issue(4'd7, 2'd0, 8'd0, 2'd0);
        issue(4'd11, 2'd0, 8'd0, 2'd0);
        sweep(0, "R3 move +1 wrap");

        // R4 multi-hop by row, R3 other directions
        issue(4'd2, 2'd0, 8'd0, 2'd0);
        issue(4'd8, 2'd2, 8'd0, 2'd0);
        issue(4'd8, 2'd2, 8'd0, 2'd0);
        issue(4'd7, 2'd0, 8'd0, 2'd1);
        issue(4'd8, 2'd3, 8'd0, 2'd0);
        issue(4'd8, 2'd1, 8'd0, 2'd0);
        issue(4'd7, 2'd0, 8'd0, 2'd2);
        issue(4'd11, 2'd0, 8'd0, 2'd0);
        sweep(1, "R4 two row hops");
        sweep(2, "R3 move -row and -1");
        check("R4 element 0 got 48", 32'(exp_mem[0][1]), 32'd48);

        // R5/R6 mask by compare
        issue(4'd2, 2'd0, 8'd0, 2'd0);
        issue(4'd9, 2'd0, 8'd20, 2'd0);
        issue(4'd1, 2'd0, 8'hAA, 2'd0);
        issue(4'd7, 2'd0, 8'd0, 2'd3);
        issue(4'd8, 2'd0, 8'd0, 2'd0);
        issue(4'd10, 2'd0, 8'd0, 2'd0);
        issue(4'd7, 2'd0, 8'd0, 2'd2);
        issue(4'd11, 2'd0, 8'd0, 2'd0);
        sweep(3, "R6 masked store skipped");
        sweep(2, "R5 compare mask then set");

        // R9 host write/read, R10 lockout
        host_write(5, 0, 8'h3C);
        host_read(5, 0, "R9 read back");
        issue(4'd0, 2'd0, 8'd0, 2'd0);
        check("R8 nop sets busy", 32'(busy), 32'd1);
        host_en = 1; host_we = 1; host_pe = 6'd5; host_addr = 2'd0; host_wdata = 8'h99;
        @(negedge clk);
        host_en = 0;
        check("R10 no ack while busy", 32'(host_ack), 32'd0);
        issue(4'd11, 2'd0, 8'd0, 2'd0);
        host_en = 1; host_we = 1; host_pe = 6'd5; host_addr = 2'd0; host_wdata = 8'h77;
        cmd_valid = 1; cmd_op = 4'd11;
        @(negedge clk);
        host_en = 0; cmd_valid = 0;
        check("R10 no ack beside command", 32'(host_ack), 32'd0);
        host_read(5, 0, "R10 memory untouched");

        // random rounds, R2 R5 R6 R7 under mixed commands
        for (int r = 0; r < 6; r++) begin
            for (int c = 0; c < 40; c++) begin
                issue(4'($urandom % 11), 2'($urandom), 8'($urandom), 2'($urandom));
                check("R8 busy during sequence", 32'(busy), 32'(exp_busy));
            end
            issue(4'd7, 2'd0, 8'd0, 2'($urandom));
            issue(4'd11, 2'd0, 8'd0, 2'd0);
            for (int a = 0; a < MD; a++) sweep(a, "R2 R7 random sequence");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule